// File: doc/BRIEF.md
# Packed Integer Vector Subtractor

This block subtracts one 256-bit vector from another, element by element. A size code splits both vectors into 32 byte, 16 halfword, 8 word or 4 doubleword elements. Every element result is the low bits of the first operand minus the second. The borrow leaving an element is dropped, so results wrap modulo the element width. One adder serves signed two's-complement and unsigned operands alike, and the block raises no status flags.

The datapath is a row of byte-wide subtractor slices. The size code decides which slice boundaries pass a borrow and which cut it. A mode code decides what fills the upper half of the destination:

- The preserving 128-bit form passes the old upper destination bits through unchanged. Its first source plays the role of the destination, and the old destination's upper half arrives on a separate port.
- The clearing 128-bit form writes zeros to the upper half.
- The full-width form computes every element.

The result and its valid flag leave through one register stage.

Top module: `psimd_sub`

## Requirements
- R1: `size_sel` codes 0, 1, 2 and 3 select element widths of 8, 16, 32 and 64 bits, giving 32, 16, 8 and 4 elements per 256-bit vector. Each element result depends only on that element's bits of `src_a` and `src_b`.
- R2: Each element result equals (A - B) mod 2^w for element width w. The borrow out of an element's top bit is discarded. Corner cases: 0 - 1 gives all ones, signed minimum minus signed maximum gives 1, and equal operands give 0.
- R3: `size_sel` codes 4 through 7 behave exactly like code 0 (byte elements).
- R4: With `mode_sel` = 0 (preserving 128-bit), `result[127:0]` holds the element differences and `result[255:128]` equals the `prev_hi` value presented with the operation.
- R5: With `mode_sel` = 1 (clearing 128-bit), `result[127:0]` holds the element differences and `result[255:128]` is zero.
- R6: With `mode_sel` = 2 (full width), all 256 result bits hold element differences. `mode_sel` = 3 behaves the same as 2.
- R7: `out_valid` is high in exactly the cycle after a cycle in which `in_valid` was high at a rising clock edge. `result` is registered and carries that operation's value in the same cycle.
- R8: While no operation is accepted (`in_valid` low), `result` keeps its last value.
- R9: A synchronous active-high `rst` clears `out_valid` and `result` to zero at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation presented this cycle |
| size_sel | input | 3 | Element width code: 0 byte, 1 halfword, 2 word, 3 doubleword, 4-7 byte |
| mode_sel | input | 2 | Upper-half policy: 0 preserve, 1 clear, 2 and 3 full width |
| src_a | input | 256 | Minuend vector |
| src_b | input | 256 | Subtrahend vector |
| prev_hi | input | 128 | Previous upper destination half, used in preserve mode |
| out_valid | output | 1 | Registered result valid |
| result | output | 256 | Registered difference vector |

## Verification
The bench builds the block with its default parameters: a 256-bit vector cut into 8-bit slices. This lets a doubleword element span eight slices, so a borrow must ripple through seven internal boundaries while being cut at three element edges. The bench sweeps every size code, including the four out-of-range ones, against every mode code. Each combination gets the wrap corner patterns and random operands, followed by a random back-to-back burst with a reset in the middle. The corner patterns make every element borrow through its full width, so any boundary that is cut or passed wrongly shows up in the compared vectors.

// File: rtl/psub_pkg.sv
package psub_pkg;

  typedef enum logic [1:0] {
    HI_PRESERVE = 2'd0,
    HI_CLEAR    = 2'd1,
    HI_FULL     = 2'd2,
    HI_FULL_ALT = 2'd3
  } hi_mode_e;

  localparam int SIZE_CODE_W = 3;
  localparam int MODE_CODE_W = 2;

  // log2 of the number of slices in one element; undefined codes fall back to 0
  function automatic logic [1:0] span_log2(input logic [SIZE_CODE_W-1:0] code);
    logic [1:0] r;
    if (code > 3'd3) r = 2'd0;
    else             r = code[1:0];
    return r;
  endfunction

endpackage

// File: rtl/psub_borrow_ctl.sv
module psub_borrow_ctl
  import psub_pkg::*;
#(
  parameter int NSLICE = 32
) (
  input  logic [SIZE_CODE_W-1:0] size_sel,
  output logic [NSLICE-1:0]      elem_start
);

  logic [1:0] lg;
  assign lg = span_log2(size_sel);

  for (genvar i = 0; i < NSLICE; i++) begin : g_start
    localparam bit AT2 = (i % 2) == 0;
    localparam bit AT4 = (i % 4) == 0;
    localparam bit AT8 = (i % 8) == 0;
    always_comb begin
      unique case (lg)
        2'd0:    elem_start[i] = 1'b1;
        2'd1:    elem_start[i] = AT2;
        2'd2:    elem_start[i] = AT4;
        default: elem_start[i] = AT8;
      endcase
    end
  end

endmodule

// File: rtl/psub_slice_chain.sv
module psub_slice_chain #(
  parameter int VEC_W   = 256,
  parameter int SLICE_W = 8
) (
  input  logic [VEC_W-1:0]         op_a,
  input  logic [VEC_W-1:0]         op_b,
  input  logic [VEC_W/SLICE_W-1:0] elem_start,
  output logic [VEC_W-1:0]         diff
);

  localparam int NSLICE = VEC_W / SLICE_W;

  // chain[i] is the no-borrow carry arriving at slice i from slice i-1
  logic [NSLICE-1:0] chain;
  assign chain[0] = 1'b0;

  for (genvar i = 0; i < NSLICE; i++) begin : g_slice
    logic cin;
    // an element start injects the +1 of two's-complement negation
    assign cin = elem_start[i] ? 1'b1 : chain[i];
    if (i < NSLICE - 1) begin : g_mid
      logic [SLICE_W:0] sum;
      assign sum = {1'b0, op_a[i*SLICE_W +: SLICE_W]}
                 + {1'b0, ~op_b[i*SLICE_W +: SLICE_W]}
                 + {{SLICE_W{1'b0}}, cin};
      assign diff[i*SLICE_W +: SLICE_W] = sum[SLICE_W-1:0];
      assign chain[i+1] = sum[SLICE_W];
    end else begin : g_top
      assign diff[i*SLICE_W +: SLICE_W] = op_a[i*SLICE_W +: SLICE_W]
                                        + ~op_b[i*SLICE_W +: SLICE_W]
                                        + {{(SLICE_W-1){1'b0}}, cin};
    end
  end

endmodule

// File: rtl/psub_half_merge.sv
module psub_half_merge
  import psub_pkg::*;
#(
  parameter int VEC_W = 256
) (
  input  hi_mode_e               mode,
  input  logic [VEC_W-1:0]       diff,
  input  logic [VEC_W/2-1:0]     prev_hi,
  output logic [VEC_W-1:0]       merged
);

  localparam int HALF_W = VEC_W / 2;

  assign merged[HALF_W-1:0] = diff[HALF_W-1:0];

  always_comb begin
    unique case (mode)
      HI_PRESERVE: merged[VEC_W-1:HALF_W] = prev_hi;
      HI_CLEAR:    merged[VEC_W-1:HALF_W] = '0;
      default:     merged[VEC_W-1:HALF_W] = diff[VEC_W-1:HALF_W];
    endcase
  end

endmodule

// File: rtl/psimd_sub.sv
module psimd_sub
  import psub_pkg::*;
#(
  parameter int VEC_W   = 256,
  parameter int SLICE_W = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic [2:0]             size_sel,
  input  logic [1:0]             mode_sel,
  input  logic [VEC_W-1:0]       src_a,
  input  logic [VEC_W-1:0]       src_b,
  input  logic [VEC_W/2-1:0]     prev_hi,
  output logic                   out_valid,
  output logic [VEC_W-1:0]       result
);

  localparam int NSLICE = VEC_W / SLICE_W;

  logic [NSLICE-1:0] elem_start;
  logic [VEC_W-1:0]  diff;
  logic [VEC_W-1:0]  merged;
  hi_mode_e          mode;

  assign mode = hi_mode_e'(mode_sel);

  psub_borrow_ctl #(.NSLICE(NSLICE)) u_ctl (
    .size_sel   (size_sel),
    .elem_start (elem_start)
  );

  psub_slice_chain #(.VEC_W(VEC_W), .SLICE_W(SLICE_W)) u_chain (
    .op_a       (src_a),
    .op_b       (src_b),
    .elem_start (elem_start),
    .diff       (diff)
  );

  psub_half_merge #(.VEC_W(VEC_W)) u_merge (
    .mode    (mode),
    .diff    (diff),
    .prev_hi (prev_hi),
    .merged  (merged)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= merged;
    end
  end

endmodule

// File: rtl/psimd_sub_chk.sv
module psimd_sub_chk #(
  parameter int VEC_W = 256
) (
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic [1:0]         mode_sel,
  input logic [VEC_W-1:0]   src_a,
  input logic [VEC_W-1:0]   src_b,
  input logic [VEC_W/2-1:0] prev_hi,
  input logic               out_valid,
  input logic [VEC_W-1:0]   result
);

  localparam int HALF_W = VEC_W / 2;

  // R7
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R7
  valid_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result));

  // R4
  hi_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode_sel == 2'd0) |=> result[VEC_W-1:HALF_W] == $past(prev_hi));

  // R5
  hi_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode_sel == 2'd1) |=> result[VEC_W-1:HALF_W] == '0);

  // R2
  equal_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode_sel[1] && src_a == src_b) |=> result == '0);

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && result == '0));

endmodule

bind psimd_sub psimd_sub_chk #(.VEC_W(VEC_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .mode_sel  (mode_sel),
  .src_a     (src_a),
  .src_b     (src_b),
  .prev_hi   (prev_hi),
  .out_valid (out_valid),
  .result    (result)
);

// File: tb/psimd_sub_test.sv
module psimd_sub_test;

  localparam int CLK_PERIOD = 10;
  localparam int VW = 256;
  localparam int HW = VW / 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [2:0]    size_sel = '0;
  logic [1:0]    mode_sel = '0;
  logic [VW-1:0] src_a = '0;
  logic [VW-1:0] src_b = '0;
  logic [HW-1:0] prev_hi = '0;
  logic          out_valid;
  logic [VW-1:0] result;

  int checks = 0;
  int errors = 0;
  bit armed = 1'b0;
  bit done = 1'b0;
  logic exp_v = 1'b0;
  logic [VW-1:0] last_res = '0;

  logic [VW-1:0] exp_q[$];
  string         tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  psimd_sub uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .size_sel(size_sel),
    .mode_sel(mode_sel), .src_a(src_a), .src_b(src_b), .prev_hi(prev_hi),
    .out_valid(out_valid), .result(result)
  );

  task automatic chk(input bit ok, input string tag, input logic [VW-1:0] act,
                     input logic [VW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int ew_of(input int sz);
    return (sz > 3) ? 8 : (8 << sz);
  endfunction

  function automatic logic [VW-1:0] ref_sub(input logic [VW-1:0] a, input logic [VW-1:0] b,
                                            input logic [HW-1:0] ph, input int sz, input int md);
    int ew;
    logic [63:0] m;
    logic [VW-1:0] r;
    ew = ew_of(sz);
    m = (ew == 64) ? '1 : ((64'd1 << ew) - 64'd1);
    r = '0;
    for (int e = 0; e < VW / ew; e++) begin
      logic [63:0] x, y, d;
      x = 64'(a >> (e * ew)) & m;
      y = 64'(b >> (e * ew)) & m;
      d = (x - y) & m;
      r = r | (VW'(d) << (e * ew));
    end
    if (md == 0)      r[VW-1:HW] = ph;
    else if (md == 1) r[VW-1:HW] = '0;
    return r;
  endfunction

  function automatic logic [VW-1:0] rep(input logic [63:0] v, input int ew);
    logic [VW-1:0] r;
    logic [63:0] m;
    m = (ew == 64) ? '1 : ((64'd1 << ew) - 64'd1);
    r = '0;
    for (int e = 0; e < VW / ew; e++) r = r | (VW'(v & m) << (e * ew));
    return r;
  endfunction

  function automatic logic [VW-1:0] rnd_vec();
    logic [VW-1:0] r;
    for (int k = 0; k < VW / 32; k++) r[k*32 +: 32] = $urandom;
    return r;
  endfunction

  function automatic string tag_of(input int sz, input int md);
    if (sz > 3)  return "R3";
    if (md == 0) return "R4";
    if (md == 1) return "R5";
    if (md == 2) return "R1";
    return "R6";
  endfunction

  task automatic send(input logic [VW-1:0] a, input logic [VW-1:0] b,
                      input logic [HW-1:0] ph, input int sz, input int md, input string tag);
    @(negedge clk);
    in_valid = 1'b1;
    src_a = a;
    src_b = b;
    prev_hi = ph;
    size_sel = 3'(sz);
    mode_sel = 2'(md);
    exp_q.push_back(ref_sub(a, b, ph, sz, md));
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
      src_a = rnd_vec();
      src_b = rnd_vec();
      prev_hi = HW'(rnd_vec());
    end
  endtask

  // bench-side model of the one-cycle valid latency
  always @(posedge clk) exp_v <= rst ? 1'b0 : in_valid;

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst) begin
      last_res = '0;
    end else if (armed) begin
      chk(out_valid == exp_v, "R7", VW'(out_valid), VW'(exp_v));
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R7", result, '0);
        end else begin
          logic [VW-1:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(result === e, t, result, e);
        end
        last_res = result;
      end else begin
        chk(result === last_res, "R8", result, last_res);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(out_valid === 1'b0, "R9", VW'(out_valid), '0);
    chk(result === '0, "R9", result, '0);
    rst = 1'b0;
    armed = 1'b1;

    for (int md = 0; md < 4; md++) begin
      for (int sz = 0; sz < 8; sz++) begin
        int ew;
        logic [63:0] mn, mx;
        logic [VW-1:0] r;
        ew = ew_of(sz);
        mn = 64'd1 << (ew - 1);
        mx = mn - 64'd1;
        // R2: zero minus one wraps to all ones in each element
        send('0, rep(64'd1, ew), HW'(rnd_vec()), sz, md, "R2");
        // R2: signed minimum minus signed maximum wraps to one
        send(rep(mn, ew), rep(mx, ew), HW'(rnd_vec()), sz, md, "R2");
        // R2: equal operands give zero
        r = rnd_vec();
        send(r, r, HW'(rnd_vec()), sz, md, "R2");
        // unsigned max minus zero and random mix
        send(rep(64'hFFFF_FFFF_FFFF_FFFF, ew), '0, HW'(rnd_vec()), sz, md, tag_of(sz, md));
        send(rnd_vec(), rnd_vec(), HW'(rnd_vec()), sz, md, tag_of(sz, md));
        idle(1);
      end
    end

    // back-to-back random burst
    for (int k = 0; k < 40; k++) begin
      int sz, md;
      sz = $urandom_range(0, 7);
      md = $urandom_range(0, 3);
      send(rnd_vec(), rnd_vec(), HW'(rnd_vec()), sz, md, tag_of(sz, md));
    end
    idle(3);

    // R9: reset in mid run clears the registered result
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(out_valid === 1'b0, "R9", VW'(out_valid), '0);
    chk(result === '0, "R9", result, '0);
    @(negedge clk);
    rst = 1'b0;

    for (int k = 0; k < 10; k++) begin
      send(rnd_vec(), rnd_vec(), HW'(rnd_vec()), 3, 2, "R6");
      idle(k % 2);
    end
    idle(4);

    chk(exp_q.size() == 0, "R7", VW'(exp_q.size()), '0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule